// File: doc/BRIEF.md
# Ping-pong clock root selector

This block is one clock root slice. It has two selector branches. Each branch picks one of eight source clocks and has its own gate. An output stage takes the gated clock of the one open branch and feeds it to a post divider. Software sees a single target field: a 3-bit source index and a 3-bit divide value. The slice decides by itself which branch a write lands on.

The slice keeps an internal toggle that names the running branch. Each write reprograms the idle branch. Before the slice may repoint that branch, the source it still holds must be running. Once it is, the slice closes the old branch gate, opens the new one, and then flips the toggle.

The sources are modelled as per-source rate strobes in the slice clock domain: one strobe is one edge of that source. A separate per-source activity flag serves as the handshake, and the slice synchronises it before use. Writes that arrive while a switch is running are held in a single pending slot, and the newest one wins.

Top module: `ppcr_root`

## Requirements
- R1: After reset, busy is 0 and both readback fields are 0. Both branches select source 0. The first branch is open and the output runs from source 0 with ratio 1.
- R2: Each accepted target write reprograms the branch that is currently closed. The first write after reset goes to the second branch. Successive writes alternate between the two branches.
- R3: A switch waits as long as the source still selected by the branch being reprogrammed has its activity flag low. During that wait, busy stays 1 and the output keeps running from the old source and ratio.
- R4: Two consecutive writes of the same source index leave both branches on that source. A later switch then needs only that source to be active.
- R5: While a branch is open, root_tick pulses once every N+1 strobes of its source, where N is the 3-bit divide field.
- R6: Within each output period, root_lvl is high for ceil((N+1)/2) source strobes, which gives a 50% duty cycle for even ratios. While no gate is open, root_lvl and root_tick stay low.
- R7: The two branch gates are never open together. The old gate closes after two strobes of the old source, and the new gate opens only after two more strobes of the new source.
- R8: busy rises on the cycle after a write and stays high until the switch completes. A write made while busy is held and applied afterwards, and the newest held write wins.
- R9: rd_sel and rd_div return the source index and divide value of the switch most recently started. They do not change while the slice is idle and no write arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slice register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Target field write strobe |
| wr_sel | input | 3 | Requested source index 0..7 |
| wr_div | input | 3 | Divide field N; the ratio is N+1 |
| src_tick | input | 8 | Per-source edge strobes, one bit per source |
| src_alive | input | 8 | Per-source activity flags, asynchronous |
| busy | output | 1 | Switch in progress or write pending |
| rd_sel | output | 3 | Readback of the target source index |
| rd_div | output | 3 | Readback of the target divide field |
| root_tick | output | 1 | One-cycle pulse per divided output period |
| root_lvl | output | 1 | Divided output level |

## Verification
The assertions check on every cycle that the two gates are never open together and that busy follows every write. They also check that a blocked switch neither advances nor repoints the branch, that the toggle moves only when a hand-over finishes, and that the divider stays quiet with both gates closed.

Some behaviour can only be shown by the bench's scenarios. These are the branch alternation, the stall on a stopped old source, the double-write equalisation and the survival of a held write. The exact output period and high time for every source and ratio also belong to the bench, which gets them by sweeping all 64 combinations.

// File: rtl/ppcr_pkg.sv
package ppcr_pkg;
    localparam int NSRC  = 8;
    localparam int SEL_W = $clog2(NSRC);
    localparam int DIV_W = 3;
    localparam int EDGES = 2;
    localparam int EC_W  = $clog2(EDGES + 1);

    typedef enum logic [1:0] {S_IDLE, S_CHK, S_CLOSE, S_OPEN} st_e;

    typedef struct packed {
        st_e                   st;
        logic                  alt;      // running branch (toggle)
        logic [1:0][SEL_W-1:0] sel;      // per-branch source index
        logic [1:0]            gate;
        logic [EC_W-1:0]       ec;       // edge count during hand-over
        logic [SEL_W-1:0]      tgt_sel;
        logic [DIV_W-1:0]      tgt_div;
        logic [DIV_W-1:0]      div;      // ratio in use
        logic                  pv;
        logic [SEL_W-1:0]      p_sel;
        logic [DIV_W-1:0]      p_div;
    } ctl_t;
endpackage

// File: rtl/ppcr_sync.sv
module ppcr_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] s_out
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [1:0] ff_d, ff_q;
        always_comb ff_d = {ff_q[0], a_in[i]};
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff_q <= '0;
            else        ff_q <= ff_d;
        end
        assign s_out[i] = ff_q[1];
    end
endmodule

// File: rtl/ppcr_div.sv
module ppcr_div #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             in_tick,
    input  logic [DIV_W-1:0] ratio_n,
    output logic             tick_o,
    output logic             lvl_o
);
    localparam int HW = DIV_W + 1;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tick;
        logic             lvl;
    } div_t;

    div_t d, q;
    logic [HW-1:0]    half;
    logic [DIV_W-1:0] nxt;

    always_comb begin
        d    = q;
        half = (HW'(ratio_n) + HW'(2)) >> 1;
        nxt  = q.cnt;
        d.tick = 1'b0;
        if (!run) begin
            d.cnt = '0;
            d.lvl = 1'b0;
        end else if (in_tick) begin
            if (q.cnt == ratio_n) begin
                nxt    = '0;
                d.tick = 1'b1;
            end else begin
                nxt = q.cnt + 1'b1;
            end
            d.cnt = nxt;
            d.lvl = HW'(nxt) < half;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tick_o = q.tick;
    assign lvl_o  = q.lvl;

    p_quiet_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!lvl_o && !tick_o));
endmodule

// File: rtl/ppcr_root.sv
module ppcr_root
    import ppcr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [DIV_W-1:0] wr_div,
    input  logic [NSRC-1:0]  src_tick,
    input  logic [NSRC-1:0]  src_alive,
    output logic             busy,
    output logic [SEL_W-1:0] rd_sel,
    output logic [DIV_W-1:0] rd_div,
    output logic             root_tick,
    output logic             root_lvl
);
    ctl_t d, q;
    logic [NSRC-1:0] alive_s;
    logic            idle_br;
    logic [SEL_W-1:0] old_in;
    logic            act_tick, new_tick, br_tick, run;

    ppcr_sync #(.W(NSRC)) u_sync (
        .clk(clk), .rst_n(rst_n), .a_in(src_alive), .s_out(alive_s)
    );

    always_comb begin
        d        = q;
        idle_br  = ~q.alt;
        old_in   = q.sel[idle_br];
        act_tick = src_tick[q.sel[q.alt]];
        new_tick = src_tick[q.sel[idle_br]];
        case (q.st)
            S_IDLE: begin
                if (q.pv) begin
                    d.st      = S_CHK;
                    d.tgt_sel = q.p_sel;
                    d.tgt_div = q.p_div;
                    d.pv      = 1'b0;
                end else if (wr_en) begin
                    d.st      = S_CHK;
                    d.tgt_sel = wr_sel;
                    d.tgt_div = wr_div;
                end
            end
            S_CHK: begin
                if (alive_s[old_in]) begin
                    d.sel[idle_br] = q.tgt_sel;
                    d.ec           = '0;
                    d.st           = S_CLOSE;
                end
            end
            S_CLOSE: begin
                if (act_tick) begin
                    if (q.ec == EC_W'(EDGES - 1)) begin
                        d.gate[q.alt] = 1'b0;
                        d.ec          = '0;
                        d.st          = S_OPEN;
                    end else begin
                        d.ec = q.ec + 1'b1;
                    end
                end
            end
            default: begin
                if (new_tick) begin
                    if (q.ec == EC_W'(EDGES - 1)) begin
                        d.gate[idle_br] = 1'b1;
                        d.alt           = idle_br;
                        d.div           = q.tgt_div;
                        d.ec            = '0;
                        d.st            = S_IDLE;
                    end else begin
                        d.ec = q.ec + 1'b1;
                    end
                end
            end
        endcase
        // hold any write that cannot start immediately; newest wins
        if (wr_en && !(q.st == S_IDLE && !q.pv)) begin
            d.pv    = 1'b1;
            d.p_sel = wr_sel;
            d.p_div = wr_div;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= S_IDLE;
            q.gate <= 2'b01;
        end else begin
            q <= d;
        end
    end

    assign br_tick = (q.gate[0] & src_tick[q.sel[0]]) | (q.gate[1] & src_tick[q.sel[1]]);
    assign run     = |q.gate;
    assign busy    = (q.st != S_IDLE) | q.pv;
    assign rd_sel  = q.tgt_sel;
    assign rd_div  = q.tgt_div;

    ppcr_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run), .in_tick(br_tick),
        .ratio_n(q.div), .tick_o(root_tick), .lvl_o(root_lvl)
    );

    p_gates_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q.gate));
    p_busy_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> busy);
    p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_CHK && !alive_s[old_in]) |=> (q.st == S_CHK && $stable(q.sel)));
    p_toggle_on_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.alt) |-> $past(q.st == S_OPEN));
    p_readback_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !wr_en) |=> ($stable(rd_sel) && $stable(rd_div)));
endmodule

// File: tb/sim_ppcr_root.sv
module sim_ppcr_root;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = '0;
    logic [2:0] wr_div = '0;
    logic [7:0] src_tick = '0;
    logic [7:0] src_alive = '1;
    logic       busy, root_tick, root_lvl;
    logic [2:0] rd_sel, rd_div;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    int pc [8];

    always #10 clk = ~clk;

    ppcr_root u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_div(wr_div),
        .src_tick(src_tick), .src_alive(src_alive), .busy(busy), .rd_sel(rd_sel),
        .rd_div(rd_div), .root_tick(root_tick), .root_lvl(root_lvl)
    );

    // source i strobes once every i+2 cycles
    initial begin
        for (int i = 0; i < 8; i++) pc[i] = 0;
        forever begin
            @(negedge clk);
            for (int i = 0; i < 8; i++) begin
                pc[i] = (pc[i] == i + 1) ? 0 : pc[i] + 1;
                src_tick[i] = (pc[i] == 0);
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input int s, input int n);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'(s); wr_div = 3'(n);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_done(output int lat);
        lat = 0;
        while (busy && lat < 3000) begin
            @(posedge clk); #1; lat++;
        end
    endtask

    task automatic set_alive(input logic [7:0] v);
        @(negedge clk);
        src_alive = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic measure(input int s, input int n, input string req);
        int p, r, half, iv, hi, w;
        p = s + 2; r = n + 1; half = (r + 1) / 2;
        w = 0;
        @(posedge clk); #1;
        while (!root_tick && w < 500) begin
            @(posedge clk); #1; w++;
        end
        iv = 0; hi = 0;
        do begin
            hi += int'(root_lvl);
            iv++;
            @(posedge clk); #1;
        end while (!root_tick && iv < 1000);
        check(iv == r * p, req, "output period", iv, r * p);
        check(hi == half * p, "R6", "high time", hi, half * p);
    endtask

    initial begin
        int lat, pold, pnew;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        // R1 reset state
        check(busy == 1'b0, "R1", "busy", int'(busy), 0);
        check(rd_sel == 3'd0, "R1", "rd_sel", int'(rd_sel), 0);
        check(rd_div == 3'd0, "R1", "rd_div", int'(rd_div), 0);
        measure(0, 0, "R1");

        // R5/R7/R9 sweep of every source and ratio
        pold = 2;
        for (int s = 0; s < 8; s++) begin
            for (int n = 0; n < 8; n++) begin
                pnew = s + 2;
                wr(s, n);
                wait_done(lat);
                check(lat >= pnew && lat <= 2 * pold + 2 * pnew + 6, "R7",
                      "hand-over latency", lat, pnew);
                check(rd_sel == 3'(s), "R9", "rd_sel", int'(rd_sel), s);
                check(rd_div == 3'(n), "R9", "rd_div", int'(rd_div), n);
                measure(s, n, "R5");
                pold = pnew;
            end
        end

        // R2/R3: after one write of 3 the idle branch still holds source 0
        wr(3, 0); wait_done(lat);   // two writes back to back equalise
        wr(3, 0); wait_done(lat);
        wr(0, 0); wait_done(lat);   // branch X on 0, other on 3
        wr(3, 0); wait_done(lat);   // reprograms the branch holding 3 -> now {0,3}, 3 running
        set_alive(8'b1111_1110);
        wr(5, 0);                   // idle branch holds 0 -> must stall
        repeat (100) @(posedge clk);
        #1;
        check(busy == 1'b1, "R3", "busy during stall", int'(busy), 1);
        measure(3, 0, "R3");
        check(busy == 1'b1, "R3", "still stalled", int'(busy), 1);
        set_alive(8'b1111_1111);
        wait_done(lat);
        check(busy == 1'b0, "R3", "released", int'(busy), 0);
        measure(5, 0, "R3");
        // now running 5, idle branch holds 3: stopping 5 must not block
        set_alive(8'b1101_1111);
        wr(1, 0);
        wait_done(lat);
        check(lat < 200, "R2", "write went to other branch", lat, 0);
        measure(1, 0, "R2");

        // R4: two equal writes leave both branches on source 4
        set_alive(8'b1111_1111);
        wr(4, 0); wait_done(lat);
        wr(4, 0); wait_done(lat);
        set_alive(8'b0001_0000);
        wr(2, 1);
        wait_done(lat);
        check(lat < 200, "R4", "switch with only source 4 alive", lat, 0);
        measure(2, 1, "R4");
        set_alive(8'b1111_1111);

        // R8: a write made while busy is kept; newest held wins
        wr(7, 0);
        @(posedge clk); #1;
        check(busy == 1'b1, "R8", "busy after write", int'(busy), 1);
        wr(1, 2);
        wr(6, 3);
        wait_done(lat);
        check(rd_sel == 3'd6, "R8", "held sel applied", int'(rd_sel), 6);
        check(rd_div == 3'd3, "R8", "held div applied", int'(rd_div), 3);
        measure(6, 3, "R8");

        // R9: readback stable while idle
        repeat (20) @(posedge clk);
        #1;
        check(rd_sel == 3'd6, "R9", "idle rd_sel", int'(rd_sel), 6);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule